// File: doc/BRIEF.md
# Multi-channel match timer bank

This block holds eight timer channels, numbered 4 to 11. Each has a 32-bit counter, a 32-bit match value and a control word, all reached through a simple register port: write strobe, read strobe, byte address, and a data word in each direction. A counter advances on one of five single-cycle rate strobes (32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external). Which strobe drives it is picked by a three-bit field in its control word. A channel compares either its own counter or the counter of its group's leader against its match value. A channel with an enable bit set records each match in a status bit. One shared interrupt line stays high while any status bit is set.

Each channel is governed by a two-state machine. In ARMED a match is reported. A match while the channel is one-shot takes it from ARMED to SPENT (transition FIRE), where further matches are ignored. A write to the channel's match or control register takes it from SPENT, or from ARMED, back to ARMED (transition REARM). A periodic channel reports a match in either state. Other options are reset-on-match, a halt bit on the upper four channels, and a snapshot: when channel 9 or 11 has its snapshot bit set, a read of its counter copies the counter of channel 8 or 10 into a snapshot register.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every counter, match register, control register, the enable register, the status register and the snapshot register read zero, and `irq` is low.
- R2: Control bits [2:0] select the count strobe: 1 selects `rate_tick[0]` (32.768 kHz), 2 selects `rate_tick[1]` (1 kHz), 3 selects `rate_tick[2]` (1 Hz), 4 selects `rate_tick[3]` (1 MHz) and 5 selects `rate_tick[4]` (external). The counter adds one on each strobe of the selected input. Codes 0, 6 and 7 hold the counter.
- R3: For channel n (4..11), the counter is at 0x40+4(n-4), the match register at 0x80+4(n-4) and the control register at 0xC0+4(n-4). The snapshot register is at 0x20, the status register at 0x14 and the enable register at 0x1C. Bit n of status and enable belongs to channel n. Writes take effect at the clock edge and reads are combinational on `addr`.
- R4: Control registers of channels 4-7 keep bits [7:0]. Those of channels 8-11 keep bits [9:0]. All higher bits read as zero.
- R5: When the counter a channel compares against is advanced by a strobe to a value equal to the channel's match value, and the channel's enable bit is set, the channel's status bit reads as set from the second clock edge after the strobe cycle.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it. `irq` is high exactly while any status bit 4..11 is set.
- R7: With control bit 3 set, a match clears the channel's own counter to zero at the edge that records the match.
- R8: With control bit 6 clear, a channel reports only its first match (FIRE to SPENT) until its match or control register is written (REARM). With bit 6 set, every match is reported.
- R9: With control bit 7 clear, channels 5-7 compare against channel 4's counter, channel 9 against channel 8's and channel 11 against channel 10's. The channel's own counter then does not advance. Channels 4, 8 and 10 always use their own counter.
- R10: On channels 8-11, control bit 8 set stops the channel's own counter whatever bits [2:0] select.
- R11: A read of channel 9's counter with its control bit 9 set copies channel 8's counter into the snapshot register. The same holds for channel 11 and channel 10. With bit 9 clear, or at any other time, the snapshot register keeps its value.
- R12: A match on a channel whose enable bit is clear sets no status bit and leaves `irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used by the snapshot capture) |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| rate_tick | input | 5 | Single-cycle count strobes: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| irq | output | 1 | Shared interrupt, high while any status bit is set |

## Verification
Counting is driven by each strobe code in turn, and by the stopped codes, so a wrong decode of the select field shows up as a wrong count. Matches are produced in four ways: on an enabled leader, on a disabled follower, on a one-shot channel hit twice with and without a rearming write, and on a periodic channel hit twice. Together these separate the ARMED and SPENT behaviour from the enable gating. A follower whose own select field is running checks that it uses the leader's count while its own counter stays still. Snapshot reads are made with the capture bit set and with it clear, on both channel pairs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int FIRST_CH = 4;
    localparam int CTL_MAX  = 10;
    localparam int CB_RESET = 3;
    localparam int CB_PERIODIC = 6;
    localparam int CB_OWN   = 7;
    localparam int CB_HALT  = 8;
    localparam int CB_SNAP  = 9;
    localparam int A_SNAP = 'h20;
    localparam int A_STAT = 'h14;
    localparam int A_IEN  = 'h1C;
    localparam int A_CNT  = 'h40;
    localparam int A_MAT  = 'h80;
    localparam int A_CTL  = 'hC0;

    typedef enum logic [0:0] {
        CH_ARMED = 1'b0,
        CH_SPENT = 1'b1
    } ch_state_e;

    // group leader of channel index k (k = channel number - 4)
    function automatic int lead_of(input int k);
        if (k < 4)      return 0;
        else if (k < 6) return 4;
        else            return 6;
    endfunction

    // channel index k captures its leader's count when its counter is read
    function automatic bit is_snapper(input int k);
        return (k >= 4) && (lead_of(k) == k - 1);
    endfunction
endpackage

// File: rtl/tmr_rate_sel.sv
module tmr_rate_sel #(
    parameter int NRATE = 5,
    parameter int SELW  = 3
) (
    input  logic [SELW-1:0]  sel,
    input  logic             halt,
    input  logic [NRATE-1:0] rate_tick,
    output logic             tick
);
    logic picked;

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NRATE; i++) begin
            if (sel == SELW'(i + 1)) picked = rate_tick[i];
        end
        tick = picked && !halt;
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW     = 32,
    parameter int CTLW   = 8,
    parameter int NRATE  = 5,
    parameter bit LEADER = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NRATE-1:0]   rate_tick,
    input  logic               cnt_we,
    input  logic               mat_we,
    input  logic               ctl_we,
    input  logic [CW-1:0]      wdata,
    input  logic [CW-1:0]      src_cnt,
    input  logic               src_fresh,
    output logic [CW-1:0]      cnt_o,
    output logic               fresh_o,
    output logic [CW-1:0]      mat_o,
    output logic [CTL_MAX-1:0] ctl_o,
    output logic               hit_o
);
    localparam int SELW = 3;

    logic [CW-1:0]   cnt_q;
    logic            fresh_q;
    logic [CW-1:0]   mat_q;
    logic [CTLW-1:0] ctl_q;
    ch_state_e       st_q, st_d;

    logic halt, sel_tick, own_tick, use_own, periodic, rearm, eq;
    logic [CW-1:0] cmp_cnt;
    logic          cmp_fresh;

    if (CTLW > CB_HALT) begin : g_halt
        assign halt = ctl_q[CB_HALT];
    end else begin : g_nohalt
        assign halt = 1'b0;
    end

    tmr_rate_sel #(.NRATE(NRATE), .SELW(SELW)) u_sel (
        .sel       (ctl_q[SELW-1:0]),
        .halt      (halt),
        .rate_tick (rate_tick),
        .tick      (sel_tick)
    );

    assign use_own   = LEADER || ctl_q[CB_OWN];
    assign own_tick  = use_own && sel_tick;
    assign cmp_cnt   = use_own ? cnt_q : src_cnt;
    assign cmp_fresh = use_own ? fresh_q : src_fresh;
    assign periodic  = ctl_q[CB_PERIODIC];
    assign rearm     = mat_we || ctl_we;
    assign eq        = cmp_fresh && (cmp_cnt == mat_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_ARMED;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_ARMED: if (rearm)                 st_d = CH_ARMED;
                      else if (eq && !periodic)  st_d = CH_SPENT;
            CH_SPENT: if (rearm)                 st_d = CH_ARMED;
            default:                             st_d = CH_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        hit_o = 1'b0;
        unique case (st_q)
            CH_ARMED: hit_o = eq;
            CH_SPENT: hit_o = eq && periodic;
            default:  hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fresh_q <= 1'b0;
            mat_q   <= '0;
            ctl_q   <= '0;
        end else begin
            if (cnt_we) begin
                cnt_q   <= wdata;
                fresh_q <= 1'b0;
            end else if (hit_o && ctl_q[CB_RESET]) begin
                cnt_q   <= '0;
                fresh_q <= 1'b0;
            end else if (own_tick) begin
                cnt_q   <= cnt_q + CW'(1);
                fresh_q <= 1'b1;
            end else begin
                fresh_q <= 1'b0;
            end
            if (mat_we) mat_q <= wdata;
            if (ctl_we) ctl_q <= wdata[CTLW-1:0];
        end
    end

    assign cnt_o   = cnt_q;
    assign fresh_o = fresh_q;
    assign mat_o   = mat_q;
    assign ctl_o   = CTL_MAX'(ctl_q);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CW    = 32,
    parameter int AW    = 8,
    parameter int NRATE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [CW-1:0]    wdata,
    output logic [CW-1:0]    rdata,
    input  logic [NRATE-1:0] rate_tick,
    output logic             irq
);
    localparam int STEP = 4;

    logic [NCH-1:0][CW-1:0]      cnt_v, mat_v, snap_val;
    logic [NCH-1:0][CTL_MAX-1:0] ctl_v;
    logic [NCH-1:0] fresh_v, hit_v, cnt_we, mat_we, ctl_we, snap_req;
    logic [NCH-1:0] status_q, enable_q, stat_clr;
    logic [CW-1:0]  snap_q;
    logic           stat_we, ien_we;

    assign stat_we  = wr_en && (addr == AW'(A_STAT));
    assign ien_we   = wr_en && (addr == AW'(A_IEN));
    assign stat_clr = stat_we ? wdata[FIRST_CH +: NCH] : '0;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        localparam int LEAD = lead_of(k);
        localparam int CTLW = (k < 4) ? 8 : 10;

        assign cnt_we[k] = wr_en && (addr == AW'(A_CNT + STEP * k));
        assign mat_we[k] = wr_en && (addr == AW'(A_MAT + STEP * k));
        assign ctl_we[k] = wr_en && (addr == AW'(A_CTL + STEP * k));

        tmr_chan #(
            .CW(CW), .CTLW(CTLW), .NRATE(NRATE), .LEADER(LEAD == k)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .rate_tick (rate_tick),
            .cnt_we    (cnt_we[k]),
            .mat_we    (mat_we[k]),
            .ctl_we    (ctl_we[k]),
            .wdata     (wdata),
            .src_cnt   (cnt_v[LEAD]),
            .src_fresh (fresh_v[LEAD]),
            .cnt_o     (cnt_v[k]),
            .fresh_o   (fresh_v[k]),
            .mat_o     (mat_v[k]),
            .ctl_o     (ctl_v[k]),
            .hit_o     (hit_v[k])
        );

        if (is_snapper(k)) begin : g_snap
            assign snap_req[k] = rd_en && (addr == AW'(A_CNT + STEP * k))
                                 && ctl_v[k][CB_SNAP];
            assign snap_val[k] = cnt_v[k-1];
        end else begin : g_nosnap
            assign snap_req[k] = 1'b0;
            assign snap_val[k] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
            snap_q   <= '0;
        end else begin
            status_q <= (status_q & ~stat_clr) | (hit_v & enable_q);
            if (ien_we) enable_q <= wdata[FIRST_CH +: NCH];
            for (int k = 0; k < NCH; k++) begin
                if (snap_req[k]) snap_q <= snap_val[k];
            end
        end
    end

    assign irq = |status_q;

    always_comb begin
        rdata = '0;
        if (addr == AW'(A_SNAP))      rdata = snap_q;
        else if (addr == AW'(A_STAT)) rdata = CW'({status_q, {FIRST_CH{1'b0}}});
        else if (addr == AW'(A_IEN))  rdata = CW'({enable_q, {FIRST_CH{1'b0}}});
        for (int k = 0; k < NCH; k++) begin
            if (addr == AW'(A_CNT + STEP * k)) rdata = cnt_v[k];
            if (addr == AW'(A_MAT + STEP * k)) rdata = mat_v[k];
            if (addr == AW'(A_CTL + STEP * k)) rdata = CW'(ctl_v[k]);
        end
    end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int NCH = 8,
    parameter int CW  = 32,
    parameter int AW  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic [AW-1:0]          addr,
    input logic [NCH-1:0]         clr_bits,
    input logic                   irq,
    input logic [NCH-1:0]         status,
    input logic [NCH-1:0]         enable,
    input logic [NCH-1:0]         hit,
    input logic [CW-1:0]          snap,
    input logic [NCH-1:0][CW-1:0] cnt
);
    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(enable)) == '0)); // R12

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'('h14) && (&clr_bits) && hit == '0) |=> (status == '0)); // R6

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|hit)); // R5

    AST_SNAP_ON_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(snap)); // R11

    for (genvar k = 0; k < NCH; k++) begin : g_step
        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(wr_en) |-> (cnt[k] == $past(cnt[k]) || cnt[k] == $past(cnt[k]) + CW'(1)
                               || cnt[k] == '0)); // R2
    end
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .clr_bits (wdata[4 +: NCH]),
    .irq      (irq),
    .status   (status_q),
    .enable   (enable_q),
    .hit      (hit_v),
    .snap     (snap_q),
    .cnt      (cnt_v)
);

// File: tb/tb_tmr_bank.sv
`timescale 1ns/1ps
module tb_tmr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  rate_tick = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t exp_q[$];
    event  mon_ev;

    always #2.5 clk = ~clk;

    tmr_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rate_tick(rate_tick), .irq(irq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = exp_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        -> mon_ev;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        #1;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        exp_q.push_back(it);
        -> mon_ev;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        rate_tick = 5'(1 << idx);
        @(negedge clk);
        rate_tick = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(8'h40, 32'h0, "R1 counter ch4");
        rd(8'hD0, 32'h0, "R1 control ch8");
        rd(8'h14, 32'h0, "R1 status");
        rd(8'h20, 32'h0, "R1 snapshot");
        chk_irq(1'b0, "R1 irq");

        // control widths
        wr(8'hC4, 32'hFFFF_FFFF);
        rd(8'hC4, 32'h0000_00FF, "R4 ch5 keeps 8 bits");
        wr(8'hD4, 32'hFFFF_FFFF);
        rd(8'hD4, 32'h0000_03FF, "R4 ch9 keeps 10 bits");
        wr(8'hC4, 32'h0);
        wr(8'hD4, 32'h0);

        // strobe selection on ch4
        wr(8'hC0, 32'h81);
        pulse(0); pulse(0); pulse(0); pulse(1);
        rd(8'h40, 32'd3, "R2 sel1 counts rate_tick[0] only");
        wr(8'hC0, 32'h84);
        pulse(3); pulse(3); pulse(0);
        rd(8'h40, 32'd5, "R2 sel4 counts rate_tick[3] only");
        wr(8'hC0, 32'h80);
        for (int i = 0; i < 5; i++) pulse(i);
        rd(8'h40, 32'd5, "R2 sel0 holds");
        wr(8'hC0, 32'h86);
        for (int i = 0; i < 5; i++) pulse(i);
        rd(8'h40, 32'd5, "R2 sel6 holds");

        // register access
        wr(8'h40, 32'd100);
        rd(8'h40, 32'd100, "R3 counter write");
        wr(8'h80, 32'd102);
        rd(8'h80, 32'd102, "R3 match write");
        wr(8'h1C, 32'h10);
        rd(8'h1C, 32'h10, "R3 enable write");

        // enabled match and W1C
        wr(8'hC0, 32'hC1);
        pulse(0); pulse(0);
        rd(8'h14, 32'h10, "R5 status bit4 set on match");
        chk_irq(1'b1, "R6 irq high");
        wr(8'h14, 32'h0);
        rd(8'h14, 32'h10, "R6 write 0 leaves status");
        wr(8'h14, 32'h10);
        rd(8'h14, 32'h0, "R6 W1C clears");
        chk_irq(1'b0, "R6 irq low");

        // disabled follower match
        wr(8'h84, 32'd103);
        pulse(0);
        rd(8'h14, 32'h0, "R12 disabled match sets nothing");
        chk_irq(1'b0, "R12 irq stays low");

        // one-shot
        wr(8'h80, 32'd104);
        wr(8'hC0, 32'h81);
        pulse(0);
        rd(8'h14, 32'h10, "R8 one-shot first match");
        wr(8'h14, 32'h10);
        wr(8'h40, 32'd103);
        pulse(0);
        rd(8'h14, 32'h0, "R8 one-shot second match ignored");
        wr(8'hC0, 32'h81);
        wr(8'h40, 32'd103);
        pulse(0);
        rd(8'h14, 32'h10, "R8 rearm by control write");
        wr(8'h14, 32'h10);
        wr(8'hC0, 32'hC1);
        wr(8'h40, 32'd103);
        pulse(0);
        rd(8'h14, 32'h10, "R8 periodic first");
        wr(8'h14, 32'h10);
        wr(8'h40, 32'd103);
        pulse(0);
        rd(8'h14, 32'h10, "R8 periodic second");
        wr(8'h14, 32'h10);

        // reset on match
        wr(8'hC0, 32'hC9);
        wr(8'h40, 32'd103);
        pulse(0);
        rd(8'h40, 32'd0, "R7 counter cleared on match");
        rd(8'h14, 32'h10, "R7 match recorded");
        wr(8'h14, 32'h10);

        // follower uses leader counter
        wr(8'h1C, 32'h30);
        wr(8'hC4, 32'h01);
        wr(8'h84, 32'd3);
        pulse(0); pulse(0); pulse(0);
        rd(8'h14, 32'h20, "R9 ch5 matched leader count");
        rd(8'h44, 32'd0, "R9 follower own counter still");
        wr(8'h14, 32'h20);
        wr(8'hC4, 32'h81);
        pulse(0); pulse(0);
        rd(8'h44, 32'd2, "R9 own counter with bit7");
        wr(8'hC4, 32'h80);

        // halt bit
        wr(8'hD0, 32'h181);
        pulse(0);
        rd(8'h50, 32'd0, "R10 halted ch8");
        wr(8'hD0, 32'h81);
        pulse(0);
        rd(8'h50, 32'd1, "R10 running ch8");

        // snapshot
        wr(8'h50, 32'h1234);
        wr(8'hD4, 32'h280);
        rd(8'h54, 32'h0, "R11 ch9 counter read");
        rd(8'h20, 32'h1234, "R11 snapshot of ch8");
        wr(8'hD4, 32'h080);
        wr(8'h50, 32'h55);
        rd(8'h54, 32'h0, "R11 ch9 read without capture");
        rd(8'h20, 32'h1234, "R11 snapshot kept");
        wr(8'h58, 32'hABC);
        wr(8'hDC, 32'h200);
        rd(8'h5C, 32'h0, "R11 ch11 counter read");
        rd(8'h20, 32'hABC, "R11 snapshot of ch10");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule